// File: doc/BRIEF.md
# Way-Selective Set-Associative Instruction Cache

This block is a 16 KB, 4-way set-associative instruction cache with 32-byte lines. It has two ways to serve a fetch.

- **Conventional fetch.** All tag arrays and all data arrays are read together. The response reports both the instruction and the index of the way that matched. A fetch controller can record that index.
- **Reuse fetch.** The controller hands the index back with the fetch. The cache then leaves every tag array idle and reads only the data sub-array of the named way. Energy spent on the other arrays is saved.

Both kinds of fetch answer in the cycle after they are accepted. The per-way tag and data enable outputs show exactly which arrays a fetch activates.

Array contents change only when a conventional fetch misses and a line is refilled. A recorded way index therefore stays correct until the next miss. The cache marks each miss with a one-cycle pulse, which the controller uses to discard every way index it has recorded.

A refill reads a whole line from the memory model over a fixed number of cycles. Fetches stall until the line is written. Within each set, the victim way is chosen round-robin.

Top module: `icw_cache`

## Requirements
- R1: After reset every line is invalid, `fetch_ready` is 1, `rsp_valid`, `miss` and `mem_rd` are 0, and every set's round-robin victim pointer starts at way 0.
- R2: A fetch is accepted in a cycle where `fetch_valid` and `fetch_ready` are both 1. When an accepted fetch has `fetch_reuse` = 0, `tag_en` and `data_en` are both 4'b1111 in that same cycle.
- R3: Exactly one cycle after acceptance, `rsp_valid` is 1. On a conventional hit, `rsp_hit` is 1, `rsp_way` is the matching way, and `rsp_instr` is the 32-bit word selected by address bits [4:2]. The set index is bits [11:5] and the tag is bits [31:12].
- R4: When an accepted fetch has `fetch_reuse` = 1, `tag_en` is 0 and `data_en` has only bit `fetch_way` set. On the next cycle `rsp_hit` is 1, `rsp_way` equals `fetch_way`, and `rsp_instr` is the word held by that way at that set and word offset. The tag is not compared, so a mismatching tag is not reported.
- R5: A conventional fetch with no valid matching tag responds with `rsp_hit` = 0. `miss` is 1 for exactly that one cycle, and `fetch_ready` is 0 in that cycle.
- R6: After a miss, `mem_rd` is 1 for exactly REFILL_LAT consecutive cycles, starting in the next cycle. Throughout, `mem_line_addr` equals the missing address bits [31:5] and `fetch_ready` stays 0. `mem_line` is written into the victim line in the last of those cycles, with word i in bits [32i+31:32i]. `fetch_ready` returns the following cycle.
- R7: Victim ways within a set follow the order 0, 1, 2, 3, 0 and so on. Each set keeps its own pointer.
- R8: A line stays in the same way, and repeated fetches report the same `rsp_way`, until a refill replaces that line.
- R9: In a cycle with no accepted fetch, all `tag_en` and `data_en` bits are 0, and `rsp_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Byte address of the instruction |
| fetch_reuse | input | 1 | Use `fetch_way` and skip the tag arrays |
| fetch_way | input | 2 | Way index for a reuse fetch |
| fetch_ready | output | 1 | Cache can accept a fetch this cycle |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Response carries a valid instruction |
| rsp_way | output | 2 | Way that supplied the instruction |
| rsp_instr | output | 32 | Instruction word |
| miss | output | 1 | One-cycle miss pulse |
| tag_en | output | 4 | Per-way tag array enable |
| data_en | output | 4 | Per-way data array enable |
| mem_rd | output | 1 | Refill read in progress |
| mem_line_addr | output | 27 | Line address being refilled |
| mem_line | input | 256 | Line data from the memory model |

## Verification
The assertions assume the following about the block's inputs:
- The controller raises `fetch_reuse` only with a way index that it obtained from an earlier conventional response, and no miss has occurred since then.
- The memory model presents a stable line on `mem_line` while `mem_rd` is high.

The stimulus keeps within these assumptions in two ways:
- Reuse fetches name a way whose contents the reference model knows to be valid.
- The memory model is a pure function of `mem_line_addr`.

One reuse fetch deliberately carries a foreign tag, to show that the cache does not re-verify the pointer. Some fetches keep `fetch_valid` high through a refill, to show that nothing is accepted while the cache stalls.

// File: rtl/icw_pkg.sv
// Shared definitions for the way-selective instruction cache.
// Assumes nothing beyond a synthesizable target.
package icw_pkg;
    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_BUSY = 1'b1
    } icw_fill_e;
endpackage

// File: rtl/icw_tag_way.sv
// One tag way: tag storage, per-line valid bits, synchronous read.
// Assumes read and write never occur in the same cycle (fetch stalls during refill).
module icw_tag_way #(
    parameter int SETS  = 128,
    parameter int TAG_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld
);
    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  vld;

    // Valid bits: cleared by reset, set when a refill writes the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    // Tag storage write, no reset needed behind the valid bits
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tags[wr_idx] <= wr_tag;
        end
    end

    // Registered read, only when the way is enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
            rd_tag <= '0;
        end else if (rd_en) begin
            rd_vld <= vld[rd_idx];
            rd_tag <= tags[rd_idx];
        end
    end
endmodule

// File: rtl/icw_data_way.sv
// One data sub-array: whole-line write, single-word synchronous read.
// Assumes read and write never occur in the same cycle.
module icw_data_way #(
    parameter int SETS   = 128,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS),
    localparam int SEL_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rd_en,
    input  logic [IDX_W-1:0]        rd_idx,
    input  logic [SEL_W-1:0]        rd_sel,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WORDS*DATA_W-1:0] wr_line,
    output logic [DATA_W-1:0]       rd_word
);
    logic [DATA_W-1:0] mem [SETS][WORDS];

    // Refill writes every word of the line at once
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int w = 0; w < WORDS; w++) begin
                mem[wr_idx][w] <= wr_line[w*DATA_W +: DATA_W];
            end
        end
    end

    // Registered word read, only when this sub-array is enabled
    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_word <= mem[rd_idx][rd_sel];
        end
    end
endmodule

// File: rtl/icw_fill_ctl.sv
// Refill sequencer: on a miss, reads a line for REFILL_LAT cycles and writes it
// into the round-robin victim of the missing set.
// Assumes miss is only raised while idle.
module icw_fill_ctl
    import icw_pkg::*;
#(
    parameter int SETS       = 128,
    parameter int WAYS       = 4,
    parameter int LADDR_W    = 27,
    parameter int REFILL_LAT = 3,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int CNT_W = $clog2(REFILL_LAT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss,
    input  logic [IDX_W-1:0]   miss_idx,
    input  logic [LADDR_W-1:0] miss_line,
    output logic               busy,
    output logic               fill_we,
    output logic [WAY_W-1:0]   fill_way,
    output logic [IDX_W-1:0]   fill_idx,
    output logic [LADDR_W-1:0] fill_line
);
    icw_fill_e        state;
    logic [CNT_W-1:0] cnt;
    logic [WAY_W-1:0] rr [SETS];

    assign busy    = (state == FILL_BUSY);
    assign fill_we = busy && (cnt == CNT_W'(REFILL_LAT - 1));

    // Sequencer: capture the miss, count the refill latency, return to idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FILL_IDLE;
            cnt       <= '0;
            fill_way  <= '0;
            fill_idx  <= '0;
            fill_line <= '0;
        end else if (!busy) begin
            if (miss) begin
                state     <= FILL_BUSY;
                cnt       <= '0;
                fill_idx  <= miss_idx;
                fill_line <= miss_line;
                fill_way  <= rr[miss_idx];
            end
        end else if (fill_we) begin
            state <= FILL_IDLE;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Per-set victim pointers advance after each completed refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rr[s] <= '0;
            end
        end else if (fill_we) begin
            rr[fill_idx] <= (rr[fill_idx] == WAY_W'(WAYS - 1)) ? '0 : rr[fill_idx] + 1'b1;
        end
    end
endmodule

// File: rtl/icw_cache.sv
// Way-selective set-associative instruction cache (top).
// A conventional fetch reads all tag and data ways and reports the hit way.
// A reuse fetch reads only the data way named by fetch_way.
// Assumes the caller raises fetch_reuse only with a way known to hold the line;
// the pointer is not checked.
module icw_cache #(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int CACHE_BYTES = 16384,
    parameter int WAYS        = 4,
    parameter int LINE_BYTES  = 32,
    parameter int REFILL_LAT  = 3,
    localparam int WAY_W     = $clog2(WAYS),
    localparam int WORDS     = LINE_BYTES / (DATA_W / 8),
    localparam int SETS      = CACHE_BYTES / (WAYS * LINE_BYTES),
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int BYTE_W    = $clog2(DATA_W / 8),
    localparam int SEL_W     = $clog2(WORDS),
    localparam int IDX_W     = $clog2(SETS),
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W,
    localparam int LADDR_W   = ADDR_W - OFF_W,
    localparam int LINE_BITS = LINE_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_valid,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic                 fetch_reuse,
    input  logic [WAY_W-1:0]     fetch_way,
    output logic                 fetch_ready,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [WAY_W-1:0]     rsp_way,
    output logic [DATA_W-1:0]    rsp_instr,
    output logic                 miss,
    output logic [WAYS-1:0]      tag_en,
    output logic [WAYS-1:0]      data_en,
    output logic                 mem_rd,
    output logic [LADDR_W-1:0]   mem_line_addr,
    input  logic [LINE_BITS-1:0] mem_line
);
    logic [IDX_W-1:0] req_idx;
    logic [TAG_W-1:0] req_tag;
    logic [SEL_W-1:0] req_sel;
    logic             fire;
    logic             busy;
    logic             fill_we;
    logic [WAY_W-1:0] fill_way;
    logic [IDX_W-1:0] fill_idx;
    logic             unused_addr_bits;

    logic               q_valid;
    logic               q_reuse;
    logic [WAY_W-1:0]   q_way;
    logic [TAG_W-1:0]   q_tag;
    logic [IDX_W-1:0]   q_idx;

    logic [TAG_W-1:0]   way_tag  [WAYS];
    logic [WAYS-1:0]    way_vld;
    logic [DATA_W-1:0]  way_word [WAYS];
    logic [WAYS-1:0]    match;
    logic [WAY_W-1:0]   match_way;
    logic               hit;

    assign req_sel          = fetch_addr[BYTE_W +: SEL_W];
    assign req_idx          = fetch_addr[OFF_W +: IDX_W];
    assign req_tag          = fetch_addr[ADDR_W-1 -: TAG_W];
    assign unused_addr_bits = ^fetch_addr[BYTE_W-1:0];

    assign fetch_ready = !busy && !miss;
    assign fire        = fetch_valid && fetch_ready;
    assign mem_rd      = busy;

    // Request stage: remember what the arrays were asked for
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_reuse <= 1'b0;
            q_way   <= '0;
            q_tag   <= '0;
            q_idx   <= '0;
        end else begin
            q_valid <= fire;
            if (fire) begin
                q_reuse <= fetch_reuse;
                q_way   <= fetch_way;
                q_tag   <= req_tag;
                q_idx   <= req_idx;
            end
        end
    end

    // Per-way arrays with their enables
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tag_en[w]  = fire && !fetch_reuse;
        assign data_en[w] = fire && (!fetch_reuse || fetch_way == WAY_W'(w));

        icw_tag_way #(.SETS(SETS), .TAG_W(TAG_W)) u_tag (
            .clk    (clk),
            .rst_n  (rst_n),
            .rd_en  (tag_en[w]),
            .rd_idx (req_idx),
            .wr_en  (fill_we && fill_way == WAY_W'(w)),
            .wr_idx (fill_idx),
            .wr_tag (mem_line_addr[LADDR_W-1 -: TAG_W]),
            .rd_tag (way_tag[w]),
            .rd_vld (way_vld[w])
        );

        icw_data_way #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
            .clk     (clk),
            .rd_en   (data_en[w]),
            .rd_idx  (req_idx),
            .rd_sel  (req_sel),
            .wr_en   (fill_we && fill_way == WAY_W'(w)),
            .wr_idx  (fill_idx),
            .wr_line (mem_line),
            .rd_word (way_word[w])
        );

        assign match[w] = way_vld[w] && (way_tag[w] == q_tag);
    end

    // Hit-way encoder, lowest index wins if ever more than one matches
    always_comb begin
        match_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (match[w]) match_way = WAY_W'(w);
        end
    end

    // Response: reuse trusts the pointer, conventional uses the comparison
    assign hit       = q_reuse || (|match);
    assign rsp_valid = q_valid;
    assign rsp_hit   = q_valid && hit;
    assign miss      = q_valid && !hit;
    assign rsp_way   = q_reuse ? q_way : match_way;
    assign rsp_instr = way_word[rsp_way];

    icw_fill_ctl #(
        .SETS(SETS), .WAYS(WAYS), .LADDR_W(LADDR_W), .REFILL_LAT(REFILL_LAT)
    ) u_fill (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss      (miss),
        .miss_idx  (q_idx),
        .miss_line ({q_tag, q_idx}),
        .busy      (busy),
        .fill_we   (fill_we),
        .fill_way  (fill_way),
        .fill_idx  (fill_idx),
        .fill_line (mem_line_addr)
    );
endmodule

// File: rtl/icw_cache_chk.sv
// Property checker for icw_cache, attached by bind below.
// Assumes rst_n is low from time zero until the arrays are initialised.
module icw_cache_chk #(
    parameter int WAYS       = 4,
    parameter int REFILL_LAT = 3,
    localparam int WAY_W = $clog2(WAYS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fetch_valid,
    input logic             fetch_reuse,
    input logic [WAY_W-1:0] fetch_way,
    input logic             fetch_ready,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_way,
    input logic             miss,
    input logic [WAYS-1:0]  tag_en,
    input logic [WAYS-1:0]  data_en,
    input logic             mem_rd
);
    logic        acc;
    logic [15:0] fill_run;

    assign acc = fetch_valid && fetch_ready;

    // Length of the current run of refill cycles
    always_ff @(posedge clk) begin
        if (!rst_n)      fill_run <= '0;
        else if (mem_rd) fill_run <= fill_run + 1'b1;
        else             fill_run <= '0;
    end

    AST_CONV_ALL_WAYS: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !fetch_reuse |-> (&tag_en) && (&data_en)); // R2
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid); // R3
    AST_REUSE_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && fetch_reuse |-> tag_en == '0 && $countones(data_en) == 1 && data_en[fetch_way]); // R4
    AST_REUSE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && fetch_reuse |=> rsp_hit && rsp_way == $past(fetch_way)); // R4
    AST_MISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !miss); // R5
    AST_MISS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> !fetch_ready && !rsp_hit); // R5
    AST_FILL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> mem_rd); // R6
    AST_FILL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !fetch_ready); // R6
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> fill_run < 16'(REFILL_LAT)); // R6
    AST_FILL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> fill_run == 16'(REFILL_LAT)); // R6
    AST_IDLE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |-> tag_en == '0 && data_en == '0); // R9
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid); // R9
endmodule

bind icw_cache icw_cache_chk #(.WAYS(WAYS), .REFILL_LAT(REFILL_LAT)) u_icw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fetch_valid (fetch_valid),
    .fetch_reuse (fetch_reuse),
    .fetch_way   (fetch_way),
    .fetch_ready (fetch_ready),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_way     (rsp_way),
    .miss        (miss),
    .tag_en      (tag_en),
    .data_en     (data_en),
    .mem_rd      (mem_rd)
);

// File: tb/test_icw_cache.sv
// Bench for icw_cache: behavioural reference model of tags, valid bits and
// victim pointers; every response and every refill cycle is compared.
module test_icw_cache;
    localparam int CLK_PERIOD  = 10;
    localparam int FILL_CYCLES = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fetch_valid = 1'b0;
    logic [31:0]  fetch_addr = '0;
    logic         fetch_reuse = 1'b0;
    logic [1:0]   fetch_way = '0;
    logic         fetch_ready;
    logic         rsp_valid;
    logic         rsp_hit;
    logic [1:0]   rsp_way;
    logic [31:0]  rsp_instr;
    logic         miss;
    logic [3:0]   tag_en;
    logic [3:0]   data_en;
    logic         mem_rd;
    logic [26:0]  mem_line_addr;
    logic [255:0] mem_line;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;
    bit  fire_q   = 1'b0;

    int  m_tag [128][4];
    bit  m_vld [128][4];
    int  m_rr  [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    icw_cache #(.REFILL_LAT(FILL_CYCLES)) i_icw_cache (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_reuse(fetch_reuse), .fetch_way(fetch_way), .fetch_ready(fetch_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_instr(rsp_instr),
        .miss(miss), .tag_en(tag_en), .data_en(data_en), .mem_rd(mem_rd),
        .mem_line_addr(mem_line_addr), .mem_line(mem_line)
    );

    function automatic logic [31:0] mword(logic [26:0] la, int w);
        return {la, w[2:0], 2'b01};
    endfunction

    function automatic logic [31:0] mk(int tag, int set, int w);
        return {tag[19:0], set[6:0], w[2:0], 2'b00};
    endfunction

    // Memory model: a pure function of the requested line address
    always_comb begin
        for (int i = 0; i < 8; i++) mem_line[i*32 +: 32] = mword(mem_line_addr, i);
    end

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Per-clock comparison: a response appears exactly when a fetch was accepted
    always @(posedge clk) fire_q <= rst_n && fetch_valid && fetch_ready;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rsp_valid == fire_q, "R3/R9 rsp_valid timing", 64'(rsp_valid), 64'(fire_q));
            if (miss) chk(!fetch_ready, "R5 stall on miss", 64'(fetch_ready), 64'd0);
        end
    end

    task automatic fetch(input int tag, input int set, input int w, input bit reuse,
                         input int ptr, input bit hold);
        int hitw;
        bit exp_miss;
        logic [31:0] exp_instr;
        @(negedge clk);
        fetch_addr  = mk(tag, set, w);
        fetch_reuse = reuse;
        fetch_way   = ptr[1:0];
        fetch_valid = 1'b1;
        #1;
        chk(fetch_ready, "R1/R6 ready before fetch", 64'(fetch_ready), 64'd1);
        if (reuse) begin
            chk(tag_en == 4'b0000, "R4 tag arrays idle", 64'(tag_en), 64'd0);
            chk(data_en == (4'b0001 << ptr), "R4 single data way", 64'(data_en), 64'(4'b0001 << ptr));
        end else begin
            chk(tag_en == 4'b1111 && data_en == 4'b1111, "R2 all ways enabled",
                64'({tag_en, data_en}), 64'hFF);
        end
        hitw = -1;
        for (int k = 3; k >= 0; k--) if (m_vld[set][k] && m_tag[set][k] == tag) hitw = k;
        if (reuse) hitw = ptr;
        exp_miss  = (hitw < 0);
        exp_instr = exp_miss ? 32'h0 : mword({m_tag[set][hitw][19:0], set[6:0]}, w);
        @(negedge clk);
        fetch_valid = exp_miss && hold;
        #1;
        chk(rsp_valid, "R3 response one cycle later", 64'(rsp_valid), 64'd1);
        chk(miss == exp_miss, "R5 miss flag", 64'(miss), 64'(exp_miss));
        chk(rsp_hit == !exp_miss, "R3 hit flag", 64'(rsp_hit), 64'(!exp_miss));
        if (!exp_miss) begin
            chk(rsp_way == hitw[1:0], reuse ? "R4 way echoed" : "R3/R8 hit way", 64'(rsp_way), 64'(hitw));
            chk(rsp_instr == exp_instr, reuse ? "R4 reuse word" : "R3 instr word",
                64'(rsp_instr), 64'(exp_instr));
        end else begin
            chk(!fetch_ready, "R5 ready low on miss", 64'(fetch_ready), 64'd0);
            for (int k = 0; k < FILL_CYCLES; k++) begin
                @(negedge clk);
                if (k == FILL_CYCLES - 1) fetch_valid = 1'b0;
                #1;
                chk(mem_rd, "R6 refill read active", 64'(mem_rd), 64'd1);
                chk(mem_line_addr == {tag[19:0], set[6:0]}, "R6 refill address",
                    64'(mem_line_addr), 64'({tag[19:0], set[6:0]}));
                chk(!miss && !fetch_ready, "R5/R6 single pulse and stall",
                    64'({miss, fetch_ready}), 64'd0);
                chk(tag_en == 0 && data_en == 0 && !rsp_valid, "R9 nothing accepted in refill",
                    64'({tag_en, data_en, rsp_valid}), 64'd0);
            end
            m_tag[set][m_rr[set]] = tag;
            m_vld[set][m_rr[set]] = 1'b1;
            m_rr[set] = (m_rr[set] + 1) % 4;
            @(negedge clk);
            #1;
            chk(!mem_rd && fetch_ready, "R6 refill ends after latency",
                64'({mem_rd, fetch_ready}), 64'b01);
        end
    endtask

    // Confirms which way a conventional fetch finds a line in (R7 victim order)
    task automatic expect_way(input int tag, input int set, input int way);
        int hitw;
        hitw = -1;
        for (int k = 3; k >= 0; k--) if (m_vld[set][k] && m_tag[set][k] == tag) hitw = k;
        chk(hitw == way, "R7 victim order", 64'(hitw), 64'(way));
        fetch(tag, set, 1, 1'b0, 0, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 128; s++) begin
            m_rr[s] = 0;
            for (int k = 0; k < 4; k++) begin m_vld[s][k] = 1'b0; m_tag[s][k] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(fetch_ready && !rsp_valid && !miss && !mem_rd, "R1 reset outputs",
            64'({fetch_ready, rsp_valid, miss, mem_rd}), 64'b1000);
        @(negedge clk); #1;
        chk(tag_en == 0 && data_en == 0, "R9 idle enables", 64'({tag_en, data_en}), 64'd0);

        // Cold miss, refill into way 0, then hits on the same line
        fetch(1, 3, 2, 1'b0, 0, 1'b1);
        fetch(1, 3, 2, 1'b0, 0, 1'b0);
        fetch(1, 3, 5, 1'b0, 0, 1'b0);
        // Fill the rest of set 3, then wrap the victim pointer
        fetch(2, 3, 0, 1'b0, 0, 1'b0);
        fetch(3, 3, 7, 1'b0, 0, 1'b1);
        fetch(4, 3, 4, 1'b0, 0, 1'b0);
        expect_way(2, 3, 1);
        expect_way(4, 3, 3);
        fetch(5, 3, 6, 1'b0, 0, 1'b0);
        expect_way(5, 3, 0);
        fetch(1, 3, 2, 1'b0, 0, 1'b0);
        expect_way(1, 3, 1);
        // Independent pointer in another set
        fetch(7, 9, 3, 1'b0, 0, 1'b0);
        expect_way(7, 9, 0);
        // Reuse with a correct pointer and with a foreign tag
        fetch(3, 3, 4, 1'b1, 2, 1'b0);
        fetch(99, 3, 0, 1'b1, 3, 1'b0);
        fetch(7, 9, 7, 1'b1, 0, 1'b0);
        // Stability of a line across repeated fetches until replacement
        fetch(4, 3, 1, 1'b0, 0, 1'b0);
        fetch(4, 3, 2, 1'b0, 0, 1'b0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule